// File: doc/BRIEF.md
# Cascaded Clock-Enable Divider with Crossing Hint

This block derives two slower timing streams from a single main clock. A first stage divides the main clock to make a fast-rate stream, and a second stage divides that fast stream again to make a system-rate stream. Neither stream is a real clock. Each one is a single-cycle enable pulse, synchronous to the main clock, marking the rising edge of the derived clock. Downstream logic uses these pulses as clock enables.

Both divide ratios load from parameters at reset. A configuration write can replace them. A new ratio is held in a shadow register and only becomes active at the end of the period that is running, so no period is ever cut short. The block also drives a hint level that is high for the whole final fast period before each system-rate edge. Logic outside the block uses it to build the enables for crossing between the two rates.

An optional gating mode lets the fast stream through only when the hint is high, which brings it down to the system rate. This mode is active when the gating enable is set and the secondary CPU reports that it is off. A static flag warns when the programmed ratios would make the system rate too slow compared with the slow reference clock.

Top module: `clkdiv_cascade`

## Requirements
- R1: Reset clears both divider counters. On the first cycle after reset is released, `fast_tick_free`, `sys_tick` and `hint` are low, as long as both ratios are above 1.
- R2: With fast ratio F, `fast_tick_free` is high on the cycles whose index k, counted in main clock edges since reset release, satisfies k mod F = F-1. The first pulse therefore comes after one full period.
- R3: With system ratio S, `sys_tick` is high exactly on the cycles where k mod (F*S) = F*S-1. Every such cycle is also a `fast_tick_free` cycle.
- R4: `hint` is high on the cycles where k mod (F*S) >= F*(S-1). It rises at the start of the last fast period of each system period and falls only after a `sys_tick` cycle.
- R5: A ratio of 1 passes the input stream through. With F=1, `fast_tick_free` is high on every cycle. With S=1, `hint` is high on every cycle and `sys_tick` equals `fast_tick_free`.
- R6: A ratio written with `cfg_we` takes effect at the next period boundary of its own stage. The period already in progress finishes with the old ratio.
- R7: A written ratio of 0 behaves exactly as a ratio of 1.
- R8: When `gate_en` and `cpu1_off` are both 1, `fast_tick` is high only on `sys_tick` cycles. Otherwise `fast_tick` equals `fast_tick_free`.
- R9: `ratio_bad` is 1 exactly when 2*F*S >= MAIN_PER_SLOW for the most recently programmed ratios, with 0 counted as 1. It updates one cycle after the write.
- R10: After reset, the active ratios are the parameter defaults FAST_DEF and SYS_DEF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for both ratio fields |
| cfg_fast_div | input | DW | New fast-stage ratio; 0 means 1 |
| cfg_sys_div | input | DW | New system-stage ratio; 0 means 1 |
| gate_en | input | 1 | Enables gating of the fast stream by the hint |
| cpu1_off | input | 1 | Secondary CPU is powered off |
| fast_tick | output | 1 | Fast-rate enable, possibly gated |
| fast_tick_free | output | 1 | Fast-rate enable, never gated |
| sys_tick | output | 1 | System-rate enable |
| hint | output | 1 | High during the final fast period before a system edge |
| ratio_bad | output | 1 | Programmed ratios break the twice-slow-clock rule |

## Verification
The assertions assume that `rst_n` is held low for at least one edge before any check counts. They also assume that `cfg_we`, `gate_en` and `cpu1_off` change only between clock edges. Beyond that, they accept any write pattern, including writes that land on a boundary cycle. The stimulus drives every input one time unit after a rising edge and holds it for whole cycles. Between periodic pattern checks it writes ratios only after a fresh reset or before a wait for a system boundary, so each pattern starts from counters at zero. The flag checks use ratios at and just below the 2*F*S = MAIN_PER_SLOW limit.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

   localparam int unsigned MAX_DW = 31;

   // A zero ratio is folded onto 1 (pass-through).
   function automatic int unsigned ratio_floor(input int unsigned r);
      return (r == 0) ? 1 : r;
   endfunction

endpackage

// File: rtl/clkdiv_stage.sv
module clkdiv_stage #(
   parameter int unsigned DW  = 8,
   parameter int unsigned DEF = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_ratio,
   input  logic          step,
   output logic          last,
   output logic          tick,
   output logic [DW-1:0] pend_ratio
);

   localparam logic [DW-1:0] DEF_V = DW'(DEF);
   localparam logic [DW-1:0] ONE_V = DW'(1);

   logic [DW-1:0] cnt_q;
   logic [DW-1:0] act_q;
   logic [DW-1:0] pend_q;
   logic [DW-1:0] next_ratio;

   initial begin
      assert (DEF >= 1 && DEF < (1 << DW))
         else $fatal(1, "clkdiv_stage: DEF out of range");
   end

   assign next_ratio = wr_en ? wr_ratio : pend_q;
   assign last       = (cnt_q == act_q - ONE_V);
   assign tick       = step & last;
   assign pend_ratio = pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= DEF_V;
      end else if (wr_en) begin
         pend_q <= wr_ratio;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= DEF_V;
      end else if (tick) begin
         act_q <= next_ratio;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (step) begin
         if (last) cnt_q <= '0;
         else      cnt_q <= cnt_q + ONE_V;
      end
   end

   a_r2_cnt_below_ratio: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < act_q);
   a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (cnt_q == '0));
   a_r2_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(cnt_q));
   a_r6_ratio_held_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(act_q));
   a_r7_ratio_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      act_q != '0);
   a_r5_unit_ratio_always_last: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q == ONE_V) |-> last);

endmodule

// File: rtl/clkdiv_rate_guard.sv
module clkdiv_rate_guard #(
   parameter int unsigned DW            = 8,
   parameter int unsigned MAIN_PER_SLOW = 7630
) (
   input  logic [DW-1:0] fast_ratio,
   input  logic [DW-1:0] sys_ratio,
   output logic          too_slow
);

   localparam int unsigned PW = 2 * DW + 1;

   logic [PW-1:0] twice_prod;
   logic [63:0]   twice_wide;

   initial begin
      assert (PW <= 64) else $fatal(1, "clkdiv_rate_guard: DW too wide");
      assert (MAIN_PER_SLOW >= 1) else $fatal(1, "clkdiv_rate_guard: bad MAIN_PER_SLOW");
   end

   assign twice_prod = ({{(DW+1){1'b0}}, fast_ratio} * {{(DW+1){1'b0}}, sys_ratio}) << 1;
   assign twice_wide = 64'(twice_prod);
   assign too_slow   = (twice_wide >= 64'(MAIN_PER_SLOW));

endmodule

// File: rtl/clkdiv_cascade.sv
module clkdiv_cascade #(
   parameter int unsigned DW            = 8,
   parameter int unsigned FAST_DEF      = 2,
   parameter int unsigned SYS_DEF       = 2,
   parameter int unsigned MAIN_PER_SLOW = 7630,
   parameter bit          GATE_SUPPORT  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [DW-1:0] cfg_fast_div,
   input  logic [DW-1:0] cfg_sys_div,
   input  logic          gate_en,
   input  logic          cpu1_off,
   output logic          fast_tick,
   output logic          fast_tick_free,
   output logic          sys_tick,
   output logic          hint,
   output logic          ratio_bad
);

   logic [DW-1:0] fast_wr;
   logic [DW-1:0] sys_wr;
   logic [DW-1:0] fast_pend;
   logic [DW-1:0] sys_pend;
   logic          fast_last;
   logic          sys_last;

   initial begin
      assert (DW >= 1 && DW <= clkdiv_pkg::MAX_DW)
         else $fatal(1, "clkdiv_cascade: DW out of range");
   end

   assign fast_wr = DW'(clkdiv_pkg::ratio_floor(32'(cfg_fast_div)));
   assign sys_wr  = DW'(clkdiv_pkg::ratio_floor(32'(cfg_sys_div)));

   clkdiv_stage #(.DW(DW), .DEF(FAST_DEF)) u_fast (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (cfg_we),
      .wr_ratio   (fast_wr),
      .step       (1'b1),
      .last       (fast_last),
      .tick       (fast_tick_free),
      .pend_ratio (fast_pend)
   );

   clkdiv_stage #(.DW(DW), .DEF(SYS_DEF)) u_sys (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (cfg_we),
      .wr_ratio   (sys_wr),
      .step       (fast_tick_free),
      .last       (sys_last),
      .tick       (sys_tick),
      .pend_ratio (sys_pend)
   );

   assign hint = sys_last;

   clkdiv_rate_guard #(.DW(DW), .MAIN_PER_SLOW(MAIN_PER_SLOW)) u_guard (
      .fast_ratio (fast_pend),
      .sys_ratio  (sys_pend),
      .too_slow   (ratio_bad)
   );

   generate
      if (GATE_SUPPORT) begin : g_gate
         logic gating_on;
         assign gating_on = gate_en & cpu1_off;
         assign fast_tick = fast_tick_free & (~gating_on | hint);

         a_r8_gated_at_sys_rate: assert property (@(posedge clk) disable iff (!rst_n)
            (gate_en && cpu1_off && fast_tick) |-> sys_tick);
      end else begin : g_nogate
         logic unused_gate_in;
         assign unused_gate_in = gate_en ^ cpu1_off ^ fast_last;
         assign fast_tick      = fast_tick_free;
      end
   endgenerate

   a_r8_gated_subset: assert property (@(posedge clk) disable iff (!rst_n)
      fast_tick |-> fast_tick_free);
   a_r3_sys_on_fast: assert property (@(posedge clk) disable iff (!rst_n)
      sys_tick |-> fast_tick_free);
   a_r4_hint_falls_after_sys: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hint) |-> $past(sys_tick));
   a_r4_hint_with_sys: assert property (@(posedge clk) disable iff (!rst_n)
      sys_tick |-> hint);
   a_r9_flag_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(ratio_bad));

endmodule

// File: tb/clkdiv_cascade_bench.sv
`timescale 1ns/1ps
module clkdiv_cascade_bench;

   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [DW-1:0] cfg_fast_div = '0;
   logic [DW-1:0] cfg_sys_div = '0;
   logic          gate_en = 1'b0;
   logic          cpu1_off = 1'b0;
   logic          fast_tick, fast_tick_free, sys_tick, hint, ratio_bad;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   clkdiv_cascade #(
      .DW(DW), .FAST_DEF(3), .SYS_DEF(4), .MAIN_PER_SLOW(30), .GATE_SUPPORT(1'b1)
   ) u_clkdiv_cascade (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
      .cfg_fast_div(cfg_fast_div), .cfg_sys_div(cfg_sys_div),
      .gate_en(gate_en), .cpu1_off(cpu1_off),
      .fast_tick(fast_tick), .fast_tick_free(fast_tick_free),
      .sys_tick(sys_tick), .hint(hint), .ratio_bad(ratio_bad)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; cfg_we = 1'b0; gate_en = 1'b0; cpu1_off = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
   endtask

   task automatic write_cfg(input int f, input int s);
      cfg_fast_div = DW'(f);
      cfg_sys_div  = DW'(s);
      cfg_we = 1'b1;
      step();
      cfg_we = 1'b0;
   endtask

   task automatic align();
      for (int i = 0; i < 4000; i++) begin
         if (sys_tick) begin
            step();
            return;
         end
         step();
      end
      check("align sys_tick seen", 0, 1);
   endtask

   task automatic run_pattern(input int f, input int s, input int n, input string req);
      int bad_f = 0, bad_s = 0, bad_h = 0, bad_g = 0;
      int first_k = -1;
      for (int k = 0; k < n; k++) begin
         int ef = ((k % f) == f - 1);
         int es = ((k % (f * s)) == f * s - 1);
         int eh = ((k % (f * s)) >= f * (s - 1));
         if (fast_tick_free != ef) begin bad_f++; if (first_k < 0) first_k = k; end
         if (sys_tick != es)       begin bad_s++; if (first_k < 0) first_k = k; end
         if (hint != eh)           begin bad_h++; if (first_k < 0) first_k = k; end
         if (fast_tick != ef)      bad_g++;
         step();
      end
      if (first_k >= 0) $display("  pattern F=%0d S=%0d first mismatch at k=%0d", f, s, first_k);
      check({req, " fast_tick_free mismatches"}, bad_f, 0);
      check({req, " sys_tick mismatches"}, bad_s, 0);
      check({req, " hint mismatches"}, bad_h, 0);
      check({req, " ungated fast_tick mismatches"}, bad_g, 0);
   endtask

   // R1, R10, R2, R3, R4: reset state and default pattern
   task automatic t_reset_defaults();
      do_reset();
      check("R1 fast_tick_free at reset", fast_tick_free, 0);
      check("R1 sys_tick at reset", sys_tick, 0);
      check("R1 hint at reset", hint, 0);
      check("R9 ratio_bad at reset", ratio_bad, 0);
      run_pattern(3, 4, 48, "R10 R2 R3 R4 defaults");
   endtask

   // R5, R2, R3, R4: other ratios, including pass-through
   task automatic t_patterns();
      do_reset();
      write_cfg(1, 3); align(); run_pattern(1, 3, 12, "R5 F=1");
      write_cfg(4, 1); align(); run_pattern(4, 1, 16, "R5 S=1");
      write_cfg(1, 1); align(); run_pattern(1, 1, 8, "R5 F=S=1");
      write_cfg(2, 5); align(); run_pattern(2, 5, 30, "R2 R3 R4 F=2 S=5");
   endtask

   // R7: zero ratios act as one
   task automatic t_zero();
      do_reset();
      write_cfg(0, 0); align(); run_pattern(1, 1, 8, "R7 zero ratios");
   endtask

   // R6: changes apply only at the stage boundary
   task automatic t_boundary();
      int bad = 0;
      do_reset();
      write_cfg(5, 4);
      for (int k = 1; k <= 12; k++) begin
         int e = (k == 2 || k == 7 || k == 12);
         if (fast_tick_free != e) bad++;
         if (k == 5) check("R6 no tick at old-ratio slot k=5 after fast change", fast_tick_free, 0);
         if (k < 12) step();
      end
      check("R6 fast stage boundary mismatches", bad, 0);
      do_reset();
      write_cfg(3, 2);
      bad = 0;
      for (int k = 1; k <= 17; k++) begin
         int e = (k == 11 || k == 17);
         if (sys_tick != e) bad++;
         if (k < 17) step();
      end
      check("R6 system stage boundary mismatches", bad, 0);
   endtask

   // R9: rate rule flag, R7 zero folding in the flag
   task automatic t_flag();
      do_reset();
      write_cfg(3, 5);  check("R9 flag at 2*F*S == limit", ratio_bad, 1);
      write_cfg(1, 14); check("R9 flag just below limit", ratio_bad, 0);
      write_cfg(0, 15); check("R9 R7 flag with zero fast ratio", ratio_bad, 1);
      write_cfg(3, 4);  check("R9 flag cleared", ratio_bad, 0);
   endtask

   // R8: hint gating of the fast stream
   task automatic t_gate();
      int bad = 0, bad_free = 0;
      do_reset();
      gate_en = 1'b1; cpu1_off = 1'b1;
      for (int k = 0; k < 24; k++) begin
         if (fast_tick != ((k % 12) == 11)) bad++;
         if (fast_tick_free != ((k % 3) == 2)) bad_free++;
         step();
      end
      check("R8 gated fast_tick mismatches", bad, 0);
      check("R8 free stream unaffected by gating", bad_free, 0);
      cpu1_off = 1'b0;
      bad = 0;
      for (int k = 24; k < 36; k++) begin
         if (fast_tick != ((k % 3) == 2)) bad++;
         step();
      end
      check("R8 no gating while cpu1 on", bad, 0);
      gate_en = 1'b0; cpu1_off = 1'b1;
      bad = 0;
      for (int k = 36; k < 48; k++) begin
         if (fast_tick != ((k % 3) == 2)) bad++;
         step();
      end
      check("R8 no gating while gate disabled", bad, 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      t_reset_defaults();
      t_patterns();
      t_zero();
      t_boundary();
      t_flag();
      t_gate();
      finish_run();
   end

   initial begin
      #(200000 * 4);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule